// File: doc/BRIEF.md
# Line Interface Mode and Loopback Controller

This block keeps the configuration of a four-port line interface and turns it into the control signals that steer each port. While reset is held, it reads two three-level strap inputs. One sets the line rate for the device. The other sets the jitter-attenuator placement for every port. Each strap arrives as a 2-bit code: 00 means low, 01 means high, and 10 means floating. When reset is released, the straps are ignored. From then on, only register writes change the stored values.

A register-control enable decides where the loopback, build-out and transmit-enable settings come from. When it is low, they come from per-port three-level pins. When it is high, they come from the per-port registers. The block drives these outputs:
- the receive-input mux select for each port
- the remote-loopback flag
- the effective build-out
- the transmit enable and power-down
- the jitter-attenuator receive/transmit selects and bandwidth

For each port it also reports which port's line (input or output) feeds that port's receiver. Ports 0 and 1 are partners, and so are ports 2 and 3.

The per-port register word wr_data uses this layout:
- [1:0] receive select
- [2] remote loopback
- [3] build-out
- [4] transmit enable
- [5] attenuator enable
- [6] attenuator path
- [7] bandwidth

A global write uses wr_data[1] as the DS3 bit and wr_data[0] as the E3 bit.

Top module: `lif_mode_ctrl`

## Requirements
- R1: While reset is held, rate strap 00 gives rate_ds3=0, rate_e3=1. Code 01 gives rate_ds3=1, rate_e3=0. Codes 10 and 11 give both 0 (STS-1). After reset the strap has no effect.
- R2: While reset is held, attenuator strap 00 sets enable=1 and path=0 in every port. Code 01 sets enable=1 and path=1. Codes 10 and 11 set enable=0 and path=0.
- R3: ja_rx[p] is enable AND NOT path. ja_tx[p] is enable AND path. Both are never 1 for the same port.
- R4: Each port's bandwidth bit resets to 1 only when the rate strap decodes to STS-1, and to 0 otherwise. ja_bw shows it.
- R5: With reg_ctl_en=1, rx_sel, rmt_lpbk, build-out and tx_en follow the port register. That register resets to receive select 00, remote loopback 0, build-out 0 and transmit enable 1.
- R6: With reg_ctl_en=0, loopback pin code 00 (or 11) gives rx_sel=00 and rmt_lpbk=0. Code 01 gives rx_sel=01 and rmt_lpbk=0. Code 10 gives rx_sel=00 and rmt_lpbk=1.
- R7: With reg_ctl_en=0, rx_sel[2p+1] is always 0, whatever the registers hold.
- R8: For rx_sel 00 and 01, rx_src_idx names the port itself. For 10 and 11 it names the partner (p XOR 1). rx_src_out equals rx_sel bit 0.
- R9: In pin mode, build-out pin code 01 gives bo_short=1, and codes 00 and 11 give 0. bo_short is 0 whenever the rate is E3 (rate_ds3=0, rate_e3=1).
- R10: A floating build-out pin (code 10) forces tx_en=0, tx_pd=1 and bo_short=0 in both modes. Otherwise tx_pd=0, and in pin mode tx_en=1.
- R11: A write with wr_en updates only the port named by wr_port. A write with wr_glb_en loads {rate_ds3, rate_e3}. A loaded value of 11 acts as STS-1, so build-out is not suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; straps are read while low |
| rate_strap | input | 2 | Three-level line-rate strap code |
| jat_strap | input | 2 | Three-level attenuator strap code |
| lpbk_pin | input | 2*NP | Per-port three-level loopback pin codes |
| bo_pin | input | 2*NP | Per-port three-level build-out pin codes |
| reg_ctl_en | input | 1 | 1: loopback/build-out/enable from registers |
| wr_en | input | 1 | Per-port register write strobe |
| wr_port | input | PW | Port addressed by wr_en |
| wr_glb_en | input | 1 | Rate register write strobe |
| wr_data | input | 8 | Write data |
| rate_ds3 | output | 1 | Rate register DS3 bit |
| rate_e3 | output | 1 | Rate register E3 bit |
| rx_sel | output | 2*NP | Effective receive-input select per port |
| rx_src_idx | output | PW*NP | Port whose line feeds each receiver |
| rx_src_out | output | NP | 1: source is the line output, 0: line input |
| rmt_lpbk | output | NP | Remote loopback per port |
| bo_short | output | NP | Effective short-cable build-out |
| tx_en | output | NP | Effective transmit enable |
| tx_pd | output | NP | Transmitter power-down |
| ja_rx | output | NP | Attenuator in receive path |
| ja_tx | output | NP | Attenuator in transmit path |
| ja_bw | output | NP | Attenuator wide-bandwidth select |

## Verification
The assertions check these invariants on every cycle:
- Pin mode never produces a redundant-channel select.
- The attenuator is never placed in both paths at once.
- E3 mode always suppresses build-out.
- A powered-down transmitter is never enabled.
- The rate bits change only after a global write.

Other behaviour can only be shown by the bench's scenarios:
- how each strap code maps to its defaults
- how each loopback and build-out pin code is decoded
- the partner pairing of the receive-source report
- that a write reaches only the addressed port

// File: rtl/lif_mode_pkg.sv
package lif_mode_pkg;
  localparam logic [1:0] TRI_LO  = 2'b00;
  localparam logic [1:0] TRI_HI  = 2'b01;
  localparam logic [1:0] TRI_FLT = 2'b10;

  typedef struct packed {
    logic       bw;
    logic       ja_path;
    logic       ja_en;
    logic       txen;
    logic       bo;
    logic       rlbk;
    logic [1:0] rsel;
  } port_cfg_t;

  // {ds3, e3}
  function automatic logic [1:0] rate_from_strap(input logic [1:0] code);
    case (code)
      TRI_LO:  return 2'b01;
      TRI_HI:  return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  // {path, enable}
  function automatic logic [1:0] ja_from_strap(input logic [1:0] code);
    case (code)
      TRI_LO:  return 2'b01;
      TRI_HI:  return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  function automatic port_cfg_t port_default(input logic [1:0] rcode,
                                             input logic [1:0] jcode);
    port_cfg_t c;
    logic [1:0] r;
    logic [1:0] j;
    r = rate_from_strap(rcode);
    j = ja_from_strap(jcode);
    c.bw      = (r[1] == r[0]);
    c.ja_path = j[1];
    c.ja_en   = j[0];
    c.txen    = 1'b1;
    c.bo      = 1'b0;
    c.rlbk    = 1'b0;
    c.rsel    = 2'b00;
    return c;
  endfunction

  // {remote, sel[1:0]}
  function automatic logic [2:0] loop_from_pin(input logic [1:0] code);
    case (code)
      TRI_HI:  return 3'b0_01;
      TRI_FLT: return 3'b1_00;
      default: return 3'b0_00;
    endcase
  endfunction

  function automatic logic is_e3(input logic ds3, input logic e3);
    return e3 && !ds3;
  endfunction
endpackage

// File: rtl/lif_rate_cfg.sv
module lif_rate_cfg
  import lif_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_strap,
  input  logic       wr_glb_en,
  input  logic [1:0] wr_glb_data,
  output logic       rate_ds3,
  output logic       rate_e3
);
  logic [1:0] rate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rate_q <= rate_from_strap(rate_strap);
    else if (wr_glb_en) rate_q <= wr_glb_data;
  end

  assign rate_ds3 = rate_q[1];
  assign rate_e3  = rate_q[0];
endmodule

// File: rtl/lif_port_cfg.sv
module lif_port_cfg
  import lif_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_strap,
  input  logic [1:0] jat_strap,
  input  logic       wr_hit,
  input  logic [7:0] wr_data,
  output port_cfg_t  cfg
);
  port_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= port_default(rate_strap, jat_strap);
    else if (wr_hit) cfg_q <= port_cfg_t'(wr_data);
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/lif_port_sel.sv
module lif_port_sel
  import lif_mode_pkg::*;
#(
  parameter int NP  = 4,
  parameter int PID = 0,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
  input  port_cfg_t     cfg,
  input  logic          reg_ctl_en,
  input  logic          e3_mode,
  input  logic [1:0]    lpbk_code,
  input  logic [1:0]    bo_code,
  output logic [1:0]    rx_sel,
  output logic [PW-1:0] src_idx,
  output logic          src_out,
  output logic          rmt,
  output logic          bo_short,
  output logic          tx_en,
  output logic          tx_pd,
  output logic          ja_rx,
  output logic          ja_tx,
  output logic          ja_bw
);
  logic [2:0] pin_loop;
  logic       bo_float;
  logic       bo_req;

  assign pin_loop = loop_from_pin(lpbk_code);
  assign bo_float = (bo_code == TRI_FLT);

  always_comb begin
    if (reg_ctl_en) begin
      rx_sel = cfg.rsel;
      rmt    = cfg.rlbk;
      bo_req = cfg.bo;
      tx_en  = cfg.txen && !bo_float;
    end else begin
      rx_sel = pin_loop[1:0];
      rmt    = pin_loop[2];
      bo_req = (bo_code == TRI_HI);
      tx_en  = !bo_float;
    end
  end

  assign tx_pd    = bo_float;
  assign bo_short = bo_req && !bo_float && !e3_mode;
  assign src_out  = rx_sel[0];
  assign src_idx  = rx_sel[1] ? PW'(PID ^ 1) : PW'(PID);
  assign ja_rx    = cfg.ja_en && !cfg.ja_path;
  assign ja_tx    = cfg.ja_en && cfg.ja_path;
  assign ja_bw    = cfg.bw;
endmodule

// File: rtl/lif_mode_ctrl.sv
module lif_mode_ctrl
  import lif_mode_pkg::*;
#(
  parameter int NP = 4,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       rate_strap,
  input  logic [1:0]       jat_strap,
  input  logic [2*NP-1:0]  lpbk_pin,
  input  logic [2*NP-1:0]  bo_pin,
  input  logic             reg_ctl_en,
  input  logic             wr_en,
  input  logic [PW-1:0]    wr_port,
  input  logic             wr_glb_en,
  input  logic [7:0]       wr_data,
  output logic             rate_ds3,
  output logic             rate_e3,
  output logic [2*NP-1:0]  rx_sel,
  output logic [PW*NP-1:0] rx_src_idx,
  output logic [NP-1:0]    rx_src_out,
  output logic [NP-1:0]    rmt_lpbk,
  output logic [NP-1:0]    bo_short,
  output logic [NP-1:0]    tx_en,
  output logic [NP-1:0]    tx_pd,
  output logic [NP-1:0]    ja_rx,
  output logic [NP-1:0]    ja_tx,
  output logic [NP-1:0]    ja_bw
);
  logic          e3_mode;
  logic [NP-1:0] wr_hit;

  lif_rate_cfg u_rate (
    .clk(clk), .rst_n(rst_n), .rate_strap(rate_strap),
    .wr_glb_en(wr_glb_en), .wr_glb_data(wr_data[1:0]),
    .rate_ds3(rate_ds3), .rate_e3(rate_e3)
  );

  assign e3_mode = is_e3(rate_ds3, rate_e3);

  for (genvar p = 0; p < NP; p++) begin : g_port
    port_cfg_t cfg;

    assign wr_hit[p] = wr_en && (wr_port == PW'(p));

    lif_port_cfg u_cfg (
      .clk(clk), .rst_n(rst_n), .rate_strap(rate_strap),
      .jat_strap(jat_strap), .wr_hit(wr_hit[p]), .wr_data(wr_data),
      .cfg(cfg)
    );

    lif_port_sel #(.NP(NP), .PID(p)) u_sel (
      .cfg(cfg), .reg_ctl_en(reg_ctl_en), .e3_mode(e3_mode),
      .lpbk_code(lpbk_pin[2*p +: 2]), .bo_code(bo_pin[2*p +: 2]),
      .rx_sel(rx_sel[2*p +: 2]), .src_idx(rx_src_idx[PW*p +: PW]),
      .src_out(rx_src_out[p]), .rmt(rmt_lpbk[p]), .bo_short(bo_short[p]),
      .tx_en(tx_en[p]), .tx_pd(tx_pd[p]), .ja_rx(ja_rx[p]),
      .ja_tx(ja_tx[p]), .ja_bw(ja_bw[p])
    );
  end
endmodule

// File: rtl/lif_mode_ctrl_chk.sv
module lif_mode_ctrl_chk #(
  parameter int NP = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_ctl_en,
  input logic            wr_glb_en,
  input logic            rate_ds3,
  input logic            rate_e3,
  input logic [2*NP-1:0] rx_sel,
  input logic [NP-1:0]   bo_short,
  input logic [NP-1:0]   tx_en,
  input logic [NP-1:0]   tx_pd,
  input logic [NP-1:0]   ja_rx,
  input logic [NP-1:0]   ja_tx
);
  for (genvar p = 0; p < NP; p++) begin : g_chk
    // R7
    pin_no_redundant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_ctl_en |-> !rx_sel[2*p+1]);
  end

  // R3
  ja_single_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ja_rx & ja_tx) == '0);

  // R9
  e3_no_buildout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_e3 && !rate_ds3) |-> (bo_short == '0));

  // R10
  pd_tx_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pd & tx_en) == '0);

  // R1
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_glb_en) |-> $stable({rate_ds3, rate_e3}));
endmodule

bind lif_mode_ctrl lif_mode_ctrl_chk #(.NP(NP)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_ctl_en(reg_ctl_en), .wr_glb_en(wr_glb_en),
  .rate_ds3(rate_ds3), .rate_e3(rate_e3), .rx_sel(rx_sel),
  .bo_short(bo_short), .tx_en(tx_en), .tx_pd(tx_pd),
  .ja_rx(ja_rx), .ja_tx(ja_tx)
);

// File: tb/lif_mode_ctrl_tb_top.sv
module lif_mode_ctrl_tb_top;
  localparam int NP = 4;
  localparam int PW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] rate_strap = 2'b00;
  logic [1:0] jat_strap = 2'b00;
  logic [2*NP-1:0] lpbk_pin = '0;
  logic [2*NP-1:0] bo_pin = '0;
  logic reg_ctl_en = 1'b0;
  logic wr_en = 1'b0;
  logic [PW-1:0] wr_port = '0;
  logic wr_glb_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic rate_ds3, rate_e3;
  logic [2*NP-1:0] rx_sel;
  logic [PW*NP-1:0] rx_src_idx;
  logic [NP-1:0] rx_src_out, rmt_lpbk, bo_short, tx_en, tx_pd, ja_rx, ja_tx, ja_bw;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  lif_mode_ctrl #(.NP(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .rate_strap(rate_strap), .jat_strap(jat_strap),
    .lpbk_pin(lpbk_pin), .bo_pin(bo_pin), .reg_ctl_en(reg_ctl_en),
    .wr_en(wr_en), .wr_port(wr_port), .wr_glb_en(wr_glb_en), .wr_data(wr_data),
    .rate_ds3(rate_ds3), .rate_e3(rate_e3), .rx_sel(rx_sel),
    .rx_src_idx(rx_src_idx), .rx_src_out(rx_src_out), .rmt_lpbk(rmt_lpbk),
    .bo_short(bo_short), .tx_en(tx_en), .tx_pd(tx_pd), .ja_rx(ja_rx),
    .ja_tx(ja_tx), .ja_bw(ja_bw)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] rs, input logic [1:0] js);
    @(negedge clk);
    rst_n = 1'b0;
    rate_strap = rs;
    jat_strap = js;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic port_wr(input int p, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_port = PW'(p); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic glb_wr(input logic [1:0] d);
    @(negedge clk);
    wr_glb_en = 1'b1; wr_data = {6'd0, d};
    @(negedge clk);
    wr_glb_en = 1'b0;
  endtask

  task automatic t_strap_e3;
    reg_ctl_en = 1'b0; lpbk_pin = '0; bo_pin = '0;
    do_reset(2'b00, 2'b00);
    chk("R1 e3 strap rate", {rate_ds3, rate_e3}, 2'b01);
    chk("R2 low ja strap rx", {ja_rx, ja_tx}, 8'hF0);
    chk("R4 e3 bw", ja_bw, 4'h0);
    chk("R6 reset sel", rx_sel, 8'h00);
    chk("R10 reset txen/pd", {tx_en, tx_pd}, 8'hF0);
    rate_strap = 2'b01; jat_strap = 2'b10;
    repeat (4) @(negedge clk);
    chk("R1 strap ignored after reset", {rate_ds3, rate_e3}, 2'b01);
    chk("R2 strap ignored after reset", {ja_rx, ja_tx}, 8'hF0);
  endtask

  task automatic t_strap_ds3_sts1;
    do_reset(2'b01, 2'b01);
    chk("R1 ds3 strap rate", {rate_ds3, rate_e3}, 2'b10);
    chk("R2 high ja strap tx", {ja_rx, ja_tx}, 8'h0F);
    chk("R4 ds3 bw", ja_bw, 4'h0);
    do_reset(2'b11, 2'b11);
    chk("R1 code11 rate", {rate_ds3, rate_e3}, 2'b00);
    chk("R2 code11 ja off", {ja_rx, ja_tx}, 8'h00);
    do_reset(2'b10, 2'b10);
    chk("R1 float rate", {rate_ds3, rate_e3}, 2'b00);
    chk("R2 float ja off", {ja_rx, ja_tx}, 8'h00);
    chk("R4 sts1 bw", ja_bw, 4'hF);
  endtask

  task automatic t_pin_loop;
    do_reset(2'b01, 2'b10);
    reg_ctl_en = 1'b0;
    lpbk_pin = {2'b11, 2'b10, 2'b01, 2'b00};
    @(negedge clk);
    chk("R6 pin loop sel", rx_sel, 8'b00_00_01_00);
    chk("R6 pin remote", rmt_lpbk, 4'b0100);
    chk("R8 pin src out", rx_src_out, 4'b0010);
    chk("R8 pin src idx", rx_src_idx, 8'hE4);
    lpbk_pin = '0;
  endtask

  task automatic t_pin_bo;
    bo_pin = {2'b01, 2'b10, 2'b00, 2'b01};
    @(negedge clk);
    chk("R9 pin bo", bo_short, 4'b1001);
    chk("R10 float bo txen", tx_en, 4'b1011);
    chk("R10 float bo pd", tx_pd, 4'b0100);
    do_reset(2'b00, 2'b10);
    bo_pin = {4{2'b01}};
    @(negedge clk);
    chk("R9 e3 forces bo 0", bo_short, 4'h0);
    bo_pin = '0;
  endtask

  task automatic t_reg_ctl;
    do_reset(2'b01, 2'b10);
    reg_ctl_en = 1'b1;
    @(negedge clk);
    chk("R5 reg defaults", {rx_sel, rmt_lpbk, tx_en}, {8'h00, 4'h0, 4'hF});
    port_wr(2, 8'hEF);
    chk("R5 reg sel", rx_sel, 8'h30);
    chk("R5 reg rmt/bo/txen", {rmt_lpbk, bo_short, tx_en}, {4'b0100, 4'b0100, 4'b1011});
    chk("R3 reg ja tx", {ja_rx, ja_tx, ja_bw}, {4'h0, 4'b0100, 4'b0100});
    chk("R8 reg src", {rx_src_idx, rx_src_out}, {8'hF4, 4'b0100});
    port_wr(1, 8'h32);
    chk("R11 only port1 written", rx_sel, 8'h38);
    chk("R8 partner of port1", rx_src_idx, 8'hF0);
    chk("R3 reg ja rx", {ja_rx, ja_tx}, {4'b0010, 4'b0100});
    reg_ctl_en = 1'b0;
    @(negedge clk);
    chk("R7 pin mode hides redundant sel", {rx_sel, rmt_lpbk}, 12'h000);
    chk("R10 pin mode txen", tx_en, 4'hF);
    reg_ctl_en = 1'b1;
    bo_pin = {2'b00, 2'b00, 2'b10, 2'b00};
    @(negedge clk);
    chk("R10 float bo in reg mode", {tx_en, tx_pd}, {4'b1001, 4'b0010});
    bo_pin = '0;
  endtask

  task automatic t_glb_wr;
    glb_wr(2'b01);
    chk("R11 glb write e3", {rate_ds3, rate_e3}, 2'b01);
    chk("R9 e3 suppresses reg bo", bo_short, 4'h0);
    glb_wr(2'b11);
    chk("R11 glb write 11", {rate_ds3, rate_e3}, 2'b11);
    chk("R11 code11 sts1 keeps bo", bo_short, 4'b0100);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_strap_e3();
    t_strap_ds3_sts1();
    t_pin_loop();
    t_pin_bo();
    t_reg_ctl();
    t_glb_wr();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule